// File: doc/BRIEF.md
# Dual-Rail Two-Level Function with Omitted-Input Completion

This block evaluates a set of Boolean functions on dual-rail encoded operands. Every input bit arrives on a true rail and a false rail. When both rails are low, the input carries no value (the space state). When exactly one rail is high, the input carries a value. The environment never raises both rails of one input. Each output is produced the same way, as a true rail and a false rail.

The first level is a set of product terms. Each term is a hold element of the C-element kind: it rises once all of its literal rails are high, falls once all of them are low, and otherwise keeps its value. Terms are given as parameters. They may be minimized, so a term can leave out inputs, and several outputs can share one term. Within the true-rail term set, and separately within the false-rail term set, every pair of terms must disagree in the polarity of at least one shared input. The second level is an OR plane that gathers the terms into the output rails.

An input that some term leaves out cannot always report its arrival through the outputs. For that reason, each input flagged as omitted has its two rails ORed together. One more hold element combines these ORed signals into a done flag, which rises when every omitted input holds a value and falls when every omitted input is back in space.

A four-state phase tracker watches the outputs together with the done flag. It tells the environment when a whole word has been taken in and when the circuit has fully returned to space. The states are:
- SPACE (0)
- FILL (1)
- VALID (2)
- DRAIN (3)

The default parameters implement a three-input AND. The true rail is x1·x2·x3. The false rail is the orthogonal cover x3(0) + x3(1)x2(0) + x3(1)x2(1)x1(0). Inputs x1 and x2 are flagged as omitted.

Top module: `dr_cor_func`

## Requirements
- R1: While `rst_n` is low, every term element and the done flag clear at once, without waiting for a clock. As a result `out_t`, `out_f` and `red_done` read 0, `phase_o` reads 0 (SPACE), `word_idle` is 1 and `word_ready` is 0.
- R2: For any complete legal input word, exactly one rail of every output is high one clock after the word is applied. Input bit i is carried on `in_t[i]` and `in_f[i]`. With the defaults, `out_t[0]` equals the AND of the three input values and `out_f[0]` is its complement.
- R3: A term element rises on the clock after all its literal rails are high and falls on the clock after all of them are low. In any other case it holds. For example, dropping only x3 from the word 111 leaves `out_t` high.
- R4: An output may become valid while inputs it does not depend on are still in space. With the defaults, x3 = 0 alone drives `out_f` high while the phase is FILL.
- R5: `red_done` rises on the clock after every omitted input holds a value. It falls on the clock after every omitted input is in space. In any other case it holds.
- R6: No output ever has both rails high.
- R7: The phase moves from SPACE to FILL on the first valid output or on `red_done` without completion. It moves from SPACE or FILL to VALID (2) once every output is valid and `red_done` is high. `word_ready` is high exactly in VALID.
- R8: The phase moves from VALID to DRAIN (3) when completion is lost before the circuit is fully in space. It moves from VALID or DRAIN to SPACE once every output is in space and `red_done` is low. `word_idle` is high exactly in SPACE.
- R9: After a complete word is applied from SPACE, `word_ready` is high two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold elements and the phase tracker |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_t | input | N_IN | True rails of the inputs |
| in_f | input | N_IN | False rails of the inputs |
| out_t | output | N_OUT | True rails of the functions |
| out_f | output | N_OUT | False rails of the functions |
| red_done | output | 1 | Completion flag of the omitted inputs |
| phase_o | output | 2 | Phase: 0 SPACE, 1 FILL, 2 VALID, 3 DRAIN |
| word_ready | output | 1 | High while a whole word is present |
| word_idle | output | 1 | High while the circuit is fully in space |

## Verification
The assertions check four properties on every cycle:
- The two rails of each output are exclusive.
- `red_done` changes only after every omitted input has reached a value, or after every omitted input has returned to space.
- `word_ready` is never raised without prior completion.
- `word_idle` is entered only from a fully spaced circuit.

The bench scenarios cover what the assertions cannot see. They check the correct function value for each of the eight words. They show the hold behaviour of a term element when only some of its literals drop. They show early evaluation from a single deciding input, the passage through FILL and DRAIN, and the two-clock latency to `word_ready`.

// File: rtl/dr_cor_pkg.sv
package dr_cor_pkg;

    typedef enum logic [1:0] {
        PH_SPACE = 2'd0,
        PH_FILL  = 2'd1,
        PH_VALID = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

endpackage

// File: rtl/dr_celem.sv
// Hold element: rises when all selected inputs are high, falls when all are low.
module dr_celem #(
    parameter int           W    = 2,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    output logic         y
);
    logic all_hi;
    logic all_lo;

    assign all_hi = &(a | ~MASK);
    assign all_lo = ~|(a & MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y <= 1'b0;
        end else if (all_hi) begin
            y <= 1'b1;
        end else if (all_lo) begin
            y <= 1'b0;
        end
    end
endmodule

// File: rtl/dr_term_plane.sv
// First level: one hold element per product term over the rail vector {in_f, in_t}.
module dr_term_plane #(
    parameter int                     N_IN     = 3,
    parameter int                     N_TERM   = 4,
    parameter logic [N_TERM*N_IN-1:0] TERM_POS = '0,
    parameter logic [N_TERM*N_IN-1:0] TERM_NEG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_t,
    input  logic [N_IN-1:0]   in_f,
    output logic [N_TERM-1:0] term
);
    localparam int RW = 2 * N_IN;

    logic [RW-1:0] rails;
    assign rails = {in_f, in_t};

    for (genvar k = 0; k < N_TERM; k++) begin : g_term
        localparam logic [RW-1:0] LIT_MASK =
            {TERM_NEG[k*N_IN +: N_IN], TERM_POS[k*N_IN +: N_IN]};
        dr_celem #(
            .W   (RW),
            .MASK(LIT_MASK)
        ) u_cel (
            .clk  (clk),
            .rst_n(rst_n),
            .a    (rails),
            .y    (term[k])
        );
    end
endmodule

// File: rtl/dr_or_plane.sv
// Second level: each output rail is the OR of the terms mapped to it.
module dr_or_plane #(
    parameter int                      N_TERM    = 4,
    parameter int                      N_OUT     = 1,
    parameter logic [N_TERM*N_OUT-1:0] TERM_TO_T = '0,
    parameter logic [N_TERM*N_OUT-1:0] TERM_TO_F = '0
) (
    input  logic [N_TERM-1:0] term,
    output logic [N_OUT-1:0]  out_t,
    output logic [N_OUT-1:0]  out_f
);
    always_comb begin
        out_t = '0;
        out_f = '0;
        for (int k = 0; k < N_TERM; k++) begin
            for (int o = 0; o < N_OUT; o++) begin
                out_t[o] = out_t[o] | (term[k] & TERM_TO_T[k*N_OUT + o]);
                out_f[o] = out_f[o] | (term[k] & TERM_TO_F[k*N_OUT + o]);
            end
        end
    end
endmodule

// File: rtl/dr_red_detect.sv
// Completion of the inputs left out by minimization.
module dr_red_detect #(
    parameter int              N_IN     = 3,
    parameter logic [N_IN-1:0] RED_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] in_t,
    input  logic [N_IN-1:0] in_f,
    output logic            done
);
    localparam bit HAS_RED = (RED_MASK != '0);

    logic [N_IN-1:0] pair_or;
    assign pair_or = in_t | in_f;

    if (HAS_RED) begin : g_det
        dr_celem #(
            .W   (N_IN),
            .MASK(RED_MASK)
        ) u_cel (
            .clk  (clk),
            .rst_n(rst_n),
            .a    (pair_or),
            .y    (done)
        );
    end else begin : g_none
        logic unused_ok;
        assign unused_ok = &{1'b0, clk, rst_n, pair_or};
        assign done      = 1'b0;
    end
endmodule

// File: rtl/dr_cor_func.sv
module dr_cor_func
    import dr_cor_pkg::*;
#(
    parameter int                      N_IN      = 3,
    parameter int                      N_OUT     = 1,
    parameter int                      N_TERM    = 4,
    parameter logic [N_TERM*N_IN-1:0]  TERM_POS  = 12'b110_100_000_111,
    parameter logic [N_TERM*N_IN-1:0]  TERM_NEG  = 12'b001_010_100_000,
    parameter logic [N_TERM*N_OUT-1:0] TERM_TO_T = 4'b0001,
    parameter logic [N_TERM*N_OUT-1:0] TERM_TO_F = 4'b1110,
    parameter logic [N_IN-1:0]         RED_MASK  = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_t,
    input  logic [N_IN-1:0]  in_f,
    output logic [N_OUT-1:0] out_t,
    output logic [N_OUT-1:0] out_f,
    output logic             red_done,
    output logic [1:0]       phase_o,
    output logic             word_ready,
    output logic             word_idle
);
    localparam bit HAS_RED = (RED_MASK != '0);

    logic [N_TERM-1:0] term;
    logic              all_valid;
    logic              any_valid;
    logic              set_ok;
    logic              reset_ok;
    phase_e            state_q;
    phase_e            state_d;

    dr_term_plane #(
        .N_IN    (N_IN),
        .N_TERM  (N_TERM),
        .TERM_POS(TERM_POS),
        .TERM_NEG(TERM_NEG)
    ) u_terms (
        .clk  (clk),
        .rst_n(rst_n),
        .in_t (in_t),
        .in_f (in_f),
        .term (term)
    );

    dr_or_plane #(
        .N_TERM   (N_TERM),
        .N_OUT    (N_OUT),
        .TERM_TO_T(TERM_TO_T),
        .TERM_TO_F(TERM_TO_F)
    ) u_or (
        .term (term),
        .out_t(out_t),
        .out_f(out_f)
    );

    dr_red_detect #(
        .N_IN    (N_IN),
        .RED_MASK(RED_MASK)
    ) u_red (
        .clk  (clk),
        .rst_n(rst_n),
        .in_t (in_t),
        .in_f (in_f),
        .done (red_done)
    );

    assign all_valid = &(out_t | out_f);
    assign any_valid = |(out_t | out_f);
    assign set_ok    = all_valid && (red_done || !HAS_RED);
    assign reset_ok  = !any_valid && !red_done;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_SPACE: begin
                if (set_ok)                      state_d = PH_VALID;
                else if (any_valid || red_done)  state_d = PH_FILL;
            end
            PH_FILL: begin
                if (set_ok)                      state_d = PH_VALID;
                else if (reset_ok)               state_d = PH_SPACE;
            end
            PH_VALID: begin
                if (!set_ok)                     state_d = reset_ok ? PH_SPACE : PH_DRAIN;
            end
            PH_DRAIN: begin
                if (reset_ok)                    state_d = PH_SPACE;
                else if (set_ok)                 state_d = PH_VALID;
            end
            default:                             state_d = PH_SPACE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_SPACE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        phase_o    = state_q;
        word_ready = (state_q == PH_VALID);
        word_idle  = (state_q == PH_SPACE);
    end
endmodule

// File: rtl/dr_cor_func_chk.sv
module dr_cor_func_chk #(
    parameter int              N_IN     = 3,
    parameter int              N_OUT    = 1,
    parameter logic [N_IN-1:0] RED_MASK = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  in_t,
    input logic [N_IN-1:0]  in_f,
    input logic [N_OUT-1:0] out_t,
    input logic [N_OUT-1:0] out_f,
    input logic             red_done,
    input logic             word_ready,
    input logic             word_idle
);
    logic red_valid;
    logic red_space;
    logic outs_valid;
    logic outs_space;

    assign red_valid  = &((in_t | in_f) | ~RED_MASK);
    assign red_space  = ~|((in_t | in_f) & RED_MASK);
    assign outs_valid = &(out_t | out_f);
    assign outs_space = ~|(out_t | out_f);

    // R6
    a_r6_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (out_t & out_f) == '0);

    // R5
    a_r5_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(red_done) |-> $past(red_valid));

    // R5
    a_r5_done_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(red_done) |-> $past(red_space));

    // R7
    a_r7_ready_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> $past(outs_valid && red_done));

    // R8
    a_r8_idle_from_space: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_idle) |-> $past(outs_space && !red_done));
endmodule

bind dr_cor_func dr_cor_func_chk #(
    .N_IN    (N_IN),
    .N_OUT   (N_OUT),
    .RED_MASK(RED_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_t      (in_t),
    .in_f      (in_f),
    .out_t     (out_t),
    .out_f     (out_f),
    .red_done  (red_done),
    .word_ready(word_ready),
    .word_idle (word_idle)
);

// File: tb/dr_cor_func_tb.sv
`timescale 1ns/1ps
module dr_cor_func_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] in_t = '0;
    logic [2:0] in_f = '0;
    logic [0:0] out_t;
    logic [0:0] out_f;
    logic       red_done;
    logic [1:0] phase_o;
    logic       word_ready;
    logic       word_idle;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dr_cor_func u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_t      (in_t),
        .in_f      (in_f),
        .out_t     (out_t),
        .out_f     (out_f),
        .red_done  (red_done),
        .phase_o   (phase_o),
        .word_ready(word_ready),
        .word_idle (word_idle)
    );

    // word value (x3 x2 x1) and expected true rail
    localparam logic [3:0] VEC [8] = '{
        4'b000_0, 4'b001_0, 4'b010_0, 4'b011_0,
        4'b100_0, 4'b101_0, 4'b110_0, 4'b111_1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [2:0] t, input logic [2:0] f);
        in_t = t;
        in_f = f;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: values during reset
        chk("R1 out_t", out_t, 0);
        chk("R1 out_f", out_f, 0);
        chk("R1 red_done", red_done, 0);
        chk("R1 phase", phase_o, 0);
        chk("R1 idle", word_idle, 1);
        chk("R1 ready", word_ready, 0);
        edges(2);
        rst_n = 1'b1;
        edges(1);

        // Table walk: R2, R9, R5, R7, R8
        for (int i = 0; i < 8; i++) begin
            logic [2:0] w;
            w = VEC[i][3:1];
            drive(w, ~w);
            edges(1);
            chk("R2 out_t", out_t, VEC[i][0]);
            chk("R2 out_f", out_f, !VEC[i][0]);
            chk("R9 ready not yet", word_ready, 0);
            edges(1);
            chk("R9 ready", word_ready, 1);
            chk("R7 phase VALID", phase_o, 2);
            chk("R5 done", red_done, 1);
            drive(3'b000, 3'b000);
            edges(1);
            chk("R2 spaced", {out_t, out_f}, 0);
            chk("R5 done fall", red_done, 0);
            edges(1);
            chk("R8 idle", word_idle, 1);
        end

        // R4: x3 = 0 alone decides the false rail
        drive(3'b000, 3'b100);
        edges(1);
        chk("R4 out_f early", out_f, 1);
        chk("R4 out_t", out_t, 0);
        chk("R5 done low", red_done, 0);
        edges(1);
        chk("R7 phase FILL", phase_o, 1);
        chk("R7 not ready", word_ready, 0);
        // x1 valid, x2 still space
        drive(3'b001, 3'b100);
        edges(2);
        chk("R5 partial omitted", red_done, 0);
        // x2 valid too
        drive(3'b011, 3'b100);
        edges(1);
        chk("R5 done rise", red_done, 1);
        edges(1);
        chk("R7 ready", word_ready, 1);
        // x1 back to space: done holds
        drive(3'b010, 3'b100);
        edges(2);
        chk("R5 done holds", red_done, 1);
        chk("R4 out_f holds", out_f, 1);
        // x3 to space: output falls, x2 still valid
        drive(3'b010, 3'b000);
        edges(1);
        chk("R3 out_f falls", out_f, 0);
        edges(1);
        chk("R8 phase DRAIN", phase_o, 3);
        drive(3'b000, 3'b000);
        edges(2);
        chk("R8 back to SPACE", phase_o, 0);

        // R3: term element holds when only some literals drop
        drive(3'b111, 3'b000);
        edges(2);
        chk("R3 out_t set", out_t, 1);
        drive(3'b011, 3'b000);
        edges(2);
        chk("R3 out_t holds", out_t, 1);
        chk("R3 still VALID", phase_o, 2);
        drive(3'b000, 3'b000);
        edges(2);
        chk("R3 out_t clear", out_t, 0);
        chk("R8 idle again", word_idle, 1);

        // R1: async reset mid-word
        drive(3'b101, 3'b010);
        edges(2);
        chk("R1 pre-reset ready", word_ready, 1);
        #3 rst_n = 1'b0;
        #1;
        chk("R1 async out_f", out_f, 0);
        chk("R1 async done", red_done, 0);
        chk("R1 async idle", word_idle, 1);
        drive(3'b000, 3'b000);
        edges(1);
        rst_n = 1'b1;
        edges(2);
        chk("R1 after release", phase_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule